// File: doc/BRIEF.md
# Flash Command Sequencer with Protocol Error Latch

This block sits between a CPU register bus and an on-chip flash back end. A command is built in a fixed order. The flash clock divider must have been written at some point since reset. The CPU then writes one address/data pair to the flash array, writes one command code, and launches the command by writing 1 to the launch bit of the status register. The sequencer latches the address, data and code, and hands them to the back end with a one-cycle start pulse.

Every bus event is checked against the legal ordering for the current step. Any step that breaks the order sets a sticky access-error flag, drops the partial command and returns the sequencer to idle. While the flag is set, no address, command or launch write has any effect. Software clears the flag by writing 1 to the error-clear bit of the status register. A stop request during a running command aborts it and raises the error flag. While the part is secured, the debug port may not issue program-type or page-erase codes.

States:
- `SQ_IDLE` (buffer empty, nothing latched).
- `SQ_ADDR` (address/data held).
- `SQ_CMD` (code held, waiting for launch).
- `SQ_RUN` (back end busy).

Transitions:
- idle→addr on an array write.
- addr→cmd on an accepted code.
- cmd→run on launch.
- run→idle on completion or stop abort.
- addr/cmd→idle on any fault.

Register select encoding on `reg_sel`:
- 0 is the clock divider.
- 1 is the command register.
- 2 is the status register.
- 3 is any other control register.

Status write bits:
- Bit 7 is launch / buffer-empty.
- Bit 4 is error-clear.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `acc_err`=0, `buf_empty`=1, `be_start`=0, `be_abort`=0, and `be_cmd`, `be_addr` and `be_data` are 0.
- R2: An array write (`arr_wr`) made in idle before any clock-divider write (`reg_sel`=0) since reset sets `acc_err`.
- R3: In `SQ_ADDR`, a command write (`reg_sel`=1) whose code is not one of 0x05, 0x20, 0x25, 0x40, 0x41 sets `acc_err`.
- R4: A second array write in `SQ_ADDR` or `SQ_CMD` sets `acc_err`. A second command write in `SQ_CMD` also sets `acc_err`.
- R5: In `SQ_ADDR`, any control-register write other than the command register sets `acc_err`. A command write in idle also sets `acc_err`.
- R6: In `SQ_CMD`, any control read, or any control write other than a status write with bit 7 = 1, sets `acc_err`.
- R7: In `SQ_CMD`, a status write with bit 7 = 0 (cancel) sets `acc_err`.
- R8: In `SQ_CMD`, a status write with bit 7 = 1 has the following effects on the next cycle:
  - `be_start` is high for exactly one cycle.
  - `buf_empty` goes to 0.
  - `be_cmd`, `be_addr` and `be_data` show the latched code, address and data.
- R9: An array write during `SQ_RUN` sets `acc_err` while the running command continues (`buf_empty` stays 0).
- R10: `be_done` during `SQ_RUN` sets `buf_empty` to 1 on the next cycle and clears the latched outputs. `be_done` at other times has no effect.
- R11: `stop_req` during `SQ_RUN` has the following effects on the next cycle:
  - `be_abort` pulses.
  - `acc_err` sets.
  - `buf_empty` returns to 1.

  `stop_req` in any other state has no effect.
- R12: With `secured`=1 and `dbg_src`=1, command codes 0x20, 0x25 and 0x40 set `acc_err`, while 0x05 and 0x41 are accepted. With `dbg_src`=0, all five codes are accepted.
- R13: `acc_err` clears only on a status write with bit 4 = 1. While it is set, array, command and launch writes change nothing at the outputs.
- R14: When a fault occurs in `SQ_ADDR` or `SQ_CMD`, the sequencer returns to idle and `be_cmd`, `be_addr` and `be_data` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 command, 2 status, 3 other |
| reg_wdata | input | 8 | Register write data |
| dbg_src | input | 1 | Current register access comes from the debug port |
| secured | input | 1 | Device is secured |
| arr_wr | input | 1 | Write strobe to a flash array address |
| arr_addr | input | AW | Flash array address |
| arr_wdata | input | DW | Flash array write data |
| stop_req | input | 1 | Stop-mode entry request |
| be_done | input | 1 | Back end reports command completion |
| be_start | output | 1 | One-cycle launch pulse to the back end |
| be_abort | output | 1 | One-cycle abort pulse to the back end |
| be_cmd | output | 8 | Latched command code |
| be_addr | output | AW | Latched array address |
| be_data | output | DW | Latched array data |
| acc_err | output | 1 | Sticky access-error flag |
| buf_empty | output | 1 | Command buffer empty flag |

## Verification
The bench builds the block with a 12-bit address and 8-bit data. With these widths, distinct address and data patterns fit in a handful of writes, and every latched value can be compared in full against the reference model. The small address space also lets randomised traffic reach every state of the sequence many times within a short run. That traffic includes faults in each state, stop and completion at random points, and secured debug writes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ADDR = 2'd1,
        SQ_CMD  = 2'd2,
        SQ_RUN  = 2'd3
    } sq_state_t;

    localparam logic [1:0] SEL_CLKDIV = 2'd0;
    localparam logic [1:0] SEL_CMD    = 2'd1;
    localparam logic [1:0] SEL_STAT   = 2'd2;
    localparam logic [1:0] SEL_OTHER  = 2'd3;

    localparam int STAT_LAUNCH_BIT = 7;
    localparam int STAT_ERRCLR_BIT = 4;

    localparam int N_LEGAL  = 5;
    localparam int N_LOCKED = 3;

    localparam logic [7:0] LEGAL_CODES  [N_LEGAL]  = '{8'h05, 8'h20, 8'h25, 8'h40, 8'h41};
    localparam logic [7:0] LOCKED_CODES [N_LOCKED] = '{8'h20, 8'h25, 8'h40};

endpackage

// File: rtl/fcs_code_check.sv
module fcs_code_check
    import fcs_pkg::*;
(
    input  logic [7:0] code,
    input  logic       dbg_src,
    input  logic       secured,
    output logic       cmd_accept
);

    logic [N_LEGAL-1:0]  legal_hit;
    logic [N_LOCKED-1:0] lock_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_LEGAL; gi++) begin : g_legal
            assign legal_hit[gi] = (code == LEGAL_CODES[gi]);
        end
        for (gi = 0; gi < N_LOCKED; gi++) begin : g_locked
            assign lock_hit[gi] = (code == LOCKED_CODES[gi]);
        end
    endgenerate

    always_comb begin
        cmd_accept = (|legal_hit) && !(secured && dbg_src && (|lock_hit));
    end

endmodule

// File: rtl/fcs_hold.sv
module fcs_hold #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cmd,
    input  logic          clr_hold,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [7:0]    cmd_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [7:0]    cmd_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
        end else if (clr_hold) begin
            addr_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (ld_addr) begin
                addr_q <= addr_in;
                data_q <= data_in;
            end
            if (ld_cmd) begin
                cmd_q <= cmd_in;
            end
        end
    end

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_sel,
    input  logic       wd_launch,
    input  logic       wd_errclr,
    input  logic       arr_wr,
    input  logic       stop_req,
    input  logic       be_done,
    input  logic       cmd_accept,
    output logic       acc_err,
    output logic       buf_empty,
    output logic       be_start,
    output logic       be_abort,
    output logic       ld_addr,
    output logic       ld_cmd,
    output logic       clr_hold
);

    sq_state_t st, st_n;
    logic err_n, be_n, div_set, div_n, start_n, abort_n;
    logic stat_wr, err_clear, fault;

    always_comb begin
        stat_wr   = reg_wr && (reg_sel == SEL_STAT);
        err_clear = stat_wr && wd_errclr;
    end

    // next-state and output decisions
    always_comb begin
        st_n     = st;
        err_n    = acc_err;
        be_n     = buf_empty;
        div_n    = div_set;
        start_n  = 1'b0;
        abort_n  = 1'b0;
        ld_addr  = 1'b0;
        ld_cmd   = 1'b0;
        clr_hold = 1'b0;
        fault    = 1'b0;
        unique case (st)
            SQ_IDLE: begin
                if (acc_err) begin
                    if (err_clear) err_n = 1'b0;
                end else if (arr_wr) begin
                    if (!div_set) begin
                        fault = 1'b1;
                    end else begin
                        ld_addr = 1'b1;
                        st_n    = SQ_ADDR;
                    end
                end else if (reg_wr) begin
                    if (reg_sel == SEL_CLKDIV) div_n = 1'b1;
                    else if (reg_sel == SEL_CMD) fault = 1'b1;
                end
            end
            SQ_ADDR: begin
                if (arr_wr) begin
                    fault = 1'b1;
                end else if (reg_wr) begin
                    if (reg_sel == SEL_CMD && cmd_accept) begin
                        ld_cmd = 1'b1;
                        st_n   = SQ_CMD;
                    end else begin
                        fault = 1'b1;
                    end
                end
            end
            SQ_CMD: begin
                if (arr_wr) begin
                    fault = 1'b1;
                end else if (stat_wr && wd_launch) begin
                    start_n = 1'b1;
                    be_n    = 1'b0;
                    st_n    = SQ_RUN;
                end else if (reg_wr || reg_rd) begin
                    fault = 1'b1;
                end
            end
            SQ_RUN: begin
                if (stop_req) begin
                    abort_n  = 1'b1;
                    err_n    = 1'b1;
                    be_n     = 1'b1;
                    clr_hold = 1'b1;
                    st_n     = SQ_IDLE;
                end else if (be_done) begin
                    be_n     = 1'b1;
                    clr_hold = 1'b1;
                    st_n     = SQ_IDLE;
                end else if (arr_wr) begin
                    err_n = 1'b1;
                end else if (acc_err && err_clear) begin
                    err_n = 1'b0;
                end
            end
            default: st_n = SQ_IDLE;
        endcase
        if (fault) begin
            err_n    = 1'b1;
            clr_hold = 1'b1;
            st_n     = SQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SQ_IDLE;
        end else begin
            st <= st_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_err   <= 1'b0;
            buf_empty <= 1'b1;
            div_set   <= 1'b0;
            be_start  <= 1'b0;
            be_abort  <= 1'b0;
        end else begin
            acc_err   <= err_n;
            buf_empty <= be_n;
            div_set   <= div_n;
            be_start  <= start_n;
            be_abort  <= abort_n;
        end
    end

    // R8
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);

    // R8
    start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> !buf_empty);

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && !err_clear) |=> acc_err);

    // R14
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> (st == SQ_IDLE || st == SQ_RUN));

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_abort |-> (acc_err && buf_empty && st == SQ_IDLE));

    // R9
    run_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_empty |-> (st == SQ_RUN));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_sel,
    input  logic [7:0]    reg_wdata,
    input  logic          dbg_src,
    input  logic          secured,
    input  logic          arr_wr,
    input  logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_wdata,
    input  logic          stop_req,
    input  logic          be_done,
    output logic          be_start,
    output logic          be_abort,
    output logic [7:0]    be_cmd,
    output logic [AW-1:0] be_addr,
    output logic [DW-1:0] be_data,
    output logic          acc_err,
    output logic          buf_empty
);

    logic cmd_accept, ld_addr, ld_cmd, clr_hold;
    logic wd_launch, wd_errclr;

    assign wd_launch = reg_wdata[STAT_LAUNCH_BIT];
    assign wd_errclr = reg_wdata[STAT_ERRCLR_BIT];

    fcs_code_check u_chk (
        .code       (reg_wdata),
        .dbg_src    (dbg_src),
        .secured    (secured),
        .cmd_accept (cmd_accept)
    );

    fcs_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_sel    (reg_sel),
        .wd_launch  (wd_launch),
        .wd_errclr  (wd_errclr),
        .arr_wr     (arr_wr),
        .stop_req   (stop_req),
        .be_done    (be_done),
        .cmd_accept (cmd_accept),
        .acc_err    (acc_err),
        .buf_empty  (buf_empty),
        .be_start   (be_start),
        .be_abort   (be_abort),
        .ld_addr    (ld_addr),
        .ld_cmd     (ld_cmd),
        .clr_hold   (clr_hold)
    );

    fcs_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (ld_addr),
        .ld_cmd   (ld_cmd),
        .clr_hold (clr_hold),
        .addr_in  (arr_addr),
        .data_in  (arr_wdata),
        .cmd_in   (reg_wdata),
        .addr_q   (be_addr),
        .data_q   (be_data),
        .cmd_q    (be_cmd)
    );

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

    localparam int AW = 12;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, dbg_src = 0, secured = 0, arr_wr = 0;
    logic stop_req = 0, be_done = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [AW-1:0] arr_addr = 0;
    logic [DW-1:0] arr_wdata = 0;
    logic be_start, be_abort, acc_err, buf_empty;
    logic [7:0] be_cmd;
    logic [AW-1:0] be_addr;
    logic [DW-1:0] be_data;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW)) dut (.*);

    // behavioural reference: state 0 idle, 1 addr, 2 cmd, 3 run
    int m_st = 0, m_cmd = 0, m_addr = 0, m_data = 0;
    bit m_err = 0, m_be = 1, m_div = 0, m_start = 0, m_abort = 0;

    function automatic bit code_ok(input int c, input bit sec, input bit dbg);
        bit legal = (c == 'h05 || c == 'h20 || c == 'h25 || c == 'h40 || c == 'h41);
        bit locked = (c == 'h20 || c == 'h25 || c == 'h40);
        return legal && !(sec && dbg && locked);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_err = 0; m_be = 1; m_div = 0; m_start = 0; m_abort = 0;
            m_cmd = 0; m_addr = 0; m_data = 0;
        end else begin
            bit swr, clr, bad;
            swr = reg_wr && reg_sel == 2;
            clr = swr && reg_wdata[4];
            bad = 0;
            m_start = 0; m_abort = 0;
            if (m_st == 3) begin
                if (stop_req) begin
                    m_abort = 1; m_err = 1; m_be = 1; m_st = 0;
                    m_cmd = 0; m_addr = 0; m_data = 0;
                end else if (be_done) begin
                    m_be = 1; m_st = 0; m_cmd = 0; m_addr = 0; m_data = 0;
                end else if (arr_wr) m_err = 1;
                else if (m_err && clr) m_err = 0;
            end else if (m_st == 0) begin
                if (m_err) begin
                    if (clr) m_err = 0;
                end else if (arr_wr) begin
                    if (!m_div) bad = 1;
                    else begin m_addr = arr_addr; m_data = arr_wdata; m_st = 1; end
                end else if (reg_wr && reg_sel == 0) m_div = 1;
                else if (reg_wr && reg_sel == 1) bad = 1;
            end else if (m_st == 1) begin
                if (arr_wr) bad = 1;
                else if (reg_wr) begin
                    if (reg_sel == 1 && code_ok(reg_wdata, secured, dbg_src)) begin
                        m_cmd = reg_wdata; m_st = 2;
                    end else bad = 1;
                end
            end else begin
                if (arr_wr) bad = 1;
                else if (swr && reg_wdata[7]) begin m_start = 1; m_be = 0; m_st = 3; end
                else if (reg_wr || reg_rd) bad = 1;
            end
            if (bad) begin
                m_err = 1; m_st = 0; m_cmd = 0; m_addr = 0; m_data = 0;
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("model acc_err", acc_err, m_err);
            chk("model buf_empty", buf_empty, m_be);
            chk("model be_start", be_start, m_start);
            chk("model be_abort", be_abort, m_abort);
            chk("model be_cmd", be_cmd, m_cmd);
            chk("model be_addr", be_addr, m_addr);
            chk("model be_data", be_data, m_data);
        end
    end

    task automatic wreg(input logic [1:0] sel, input logic [7:0] d, input logic dbg = 0);
        reg_wr = 1; reg_sel = sel; reg_wdata = d; dbg_src = dbg;
        @(negedge clk);
        reg_wr = 0; dbg_src = 0;
    endtask

    task automatic rreg(input logic [1:0] sel);
        reg_rd = 1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic warr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        arr_wr = 1; arr_addr = a; arr_wdata = d;
        @(negedge clk);
        arr_wr = 0;
    endtask

    task automatic pulse_done();
        be_done = 1; @(negedge clk); be_done = 0;
    endtask

    task automatic pulse_stop();
        stop_req = 1; @(negedge clk); stop_req = 0;
    endtask

    task automatic clear_err();
        wreg(2'd2, 8'h10);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 acc_err", acc_err, 0);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 be_start", be_start, 0);
        chk("R1 be_cmd", be_cmd, 0);

        // R2 array write before divider
        warr(12'h010, 8'h11);
        chk("R2 acc_err", acc_err, 1);
        clear_err();
        chk("R13 clear", acc_err, 0);

        // R8 launch
        wreg(2'd0, 8'h07);
        warr(12'h123, 8'hA5);
        wreg(2'd1, 8'h20);
        wreg(2'd2, 8'h80);
        chk("R8 be_start", be_start, 1);
        chk("R8 buf_empty", buf_empty, 0);
        chk("R8 be_cmd", be_cmd, 8'h20);
        chk("R8 be_addr", be_addr, 12'h123);
        chk("R8 be_data", be_data, 8'hA5);
        @(negedge clk);
        chk("R8 one cycle", be_start, 0);
        // R9 array write while running
        warr(12'h200, 8'h01);
        chk("R9 acc_err", acc_err, 1);
        chk("R9 buf_empty", buf_empty, 0);
        pulse_done();
        chk("R10 buf_empty", buf_empty, 1);
        chk("R10 be_cmd", be_cmd, 0);
        clear_err();

        // R3 illegal code
        warr(12'h321, 8'h5A);
        wreg(2'd1, 8'h21);
        chk("R3 acc_err", acc_err, 1);
        chk("R14 be_addr", be_addr, 0);
        clear_err();

        // R4 double writes
        warr(12'h001, 8'h01);
        warr(12'h002, 8'h02);
        chk("R4 second addr", acc_err, 1);
        clear_err();
        warr(12'h003, 8'h03);
        wreg(2'd1, 8'h05);
        wreg(2'd1, 8'h05);
        chk("R4 second cmd", acc_err, 1);
        chk("R14 be_cmd", be_cmd, 0);
        clear_err();

        // R5 wrong register after address, command in idle
        warr(12'h004, 8'h04);
        wreg(2'd3, 8'h00);
        chk("R5 other write", acc_err, 1);
        clear_err();
        wreg(2'd1, 8'h05);
        chk("R5 cmd in idle", acc_err, 1);
        clear_err();

        // R6 read after command
        warr(12'h005, 8'h05);
        wreg(2'd1, 8'h41);
        rreg(2'd0);
        chk("R6 read", acc_err, 1);
        clear_err();

        // R7 cancel
        warr(12'h006, 8'h06);
        wreg(2'd1, 8'h40);
        wreg(2'd2, 8'h00);
        chk("R7 cancel", acc_err, 1);
        clear_err();

        // R11 stop
        pulse_stop();
        chk("R11 idle stop", acc_err, 0);
        warr(12'h007, 8'h07);
        wreg(2'd1, 8'h25);
        wreg(2'd2, 8'h80);
        pulse_stop();
        chk("R11 be_abort", be_abort, 1);
        chk("R11 acc_err", acc_err, 1);
        chk("R11 buf_empty", buf_empty, 1);
        clear_err();

        // R12 secured debug
        secured = 1;
        warr(12'h008, 8'h08);
        wreg(2'd1, 8'h25, 1'b1);
        chk("R12 locked", acc_err, 1);
        clear_err();
        warr(12'h009, 8'h09);
        wreg(2'd1, 8'h41, 1'b1);
        chk("R12 mass erase ok", acc_err, 0);
        wreg(2'd2, 8'h80);
        chk("R12 start", be_start, 1);
        pulse_done();
        warr(12'h00A, 8'h0A);
        wreg(2'd1, 8'h20, 1'b0);
        chk("R12 cpu ok", acc_err, 0);
        wreg(2'd2, 8'h80);
        pulse_done();
        secured = 0;

        // R13 blocked while set
        wreg(2'd1, 8'h05);
        warr(12'h0BB, 8'hBB);
        chk("R13 addr ignored", be_addr, 0);
        chk("R13 still set", acc_err, 1);
        wreg(2'd2, 8'h80);
        chk("R13 no start", be_start, 0);
        wreg(2'd2, 8'h00);
        chk("R13 zero write", acc_err, 1);
        clear_err();
        chk("R13 cleared", acc_err, 0);

        // randomised traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 10);
            secured = $urandom_range(0, 1);
            case (op)
                0: warr(AW'($urandom), DW'($urandom));
                1: wreg(2'd0, 8'($urandom));
                2: begin
                    int k = $urandom_range(0, 4);
                    wreg(2'd1, (k == 0) ? 8'h05 : (k == 1) ? 8'h20 : (k == 2) ? 8'h25 :
                               (k == 3) ? 8'h40 : 8'h41, 1'($urandom));
                end
                3: wreg(2'd1, 8'($urandom), 1'($urandom));
                4: wreg(2'd2, 8'h80);
                5: clear_err();
                6: wreg(2'($urandom), 8'($urandom));
                7: rreg(2'($urandom));
                8: pulse_done();
                9: pulse_stop();
                default: @(negedge clk);
            endcase
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule